// File: doc/BRIEF.md
# Fault-Guarded PWM Generator

This block produces a single pulse-width-modulated output from a 32-bit period and a 32-bit duty value. A period/duty pair is first captured into staging registers by a load strobe. Before the output may toggle, a hardware guard checks that the staged pair is legal. A small supervisory state machine moves between idle, a one-cycle check, running and fault states. Any illegal pair seen during the check, or loaded while running, drives the machine into a latched fault state. In that state the output is held low and the first fault cause is kept.

Leaving the fault state takes a two-step handshake on dedicated pins. First the enable request must be seen low for at least one cycle, which arms recovery. Then a clear strobe must arrive while the enable request is still low and the staged configuration is legal. No other path clears the fault. A legal configuration loaded during a run does not change the waveform until the current period ends, so no shortened or stretched pulse can appear.

Top module: `pwm_guard_top`

## Requirements
- R1: While reset is applied and after it is released, status reads IDLE, the output is low and the fault code is 0. Status encodes IDLE=0, CHECK=1, RUN=2, FAULT=3.
- R2: In IDLE, a high enable request moves status to CHECK on the next clock. CHECK lasts exactly one cycle and goes to RUN when the staged configuration is legal. The output is low in IDLE and in CHECK.
- R3: A staged configuration is illegal if period is 0 (code 1), else if period is below MIN_PERIOD (code 2), else if duty exceeds period (code 3), with priority in that order. An illegal configuration in CHECK moves status to FAULT.
- R4: In RUN, an internal count starts at 0 in the first RUN cycle and steps from 0 to period−1 and around again. The output is high exactly while count < duty, so duty 0 gives a constant low and duty = period gives a constant high.
- R5: FAULT is latched and the output stays low throughout it.
- R6: FAULT is left for IDLE only when clear is high, enable is low in that cycle and was low in the previous FAULT cycle, and the staged configuration is legal. Clear with enable high, clear in the first cycle enable drops, or clear with an illegal configuration leaves status in FAULT. Leaving FAULT resets the fault code to 0.
- R7: A load strobe captures period and duty into the staging registers in any state. In RUN, legal new values take effect only after the cycle in which the count equals period−1.
- R8: An illegal configuration loaded in RUN keeps status at RUN for the cycle after the load and moves it to FAULT on the following clock, with the output low.
- R9: The fault code holds the cause recorded on entry to FAULT. Later loads made while in FAULT do not change it.
- R10: Dropping the enable request in RUN with a legal configuration returns status to IDLE on the next clock, with the output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_period | input | 32 | Period value in clock cycles, captured on load |
| cfg_duty | input | 32 | High-time value in clock cycles, captured on load |
| cfg_load | input | 1 | Load strobe for period and duty |
| enable_req | input | 1 | Request to run the output |
| clear_strobe | input | 1 | Recovery clear, effective only when armed |
| pwm_out | output | 1 | PWM output |
| state_o | output | 2 | Supervisor state: IDLE=0, CHECK=1, RUN=2, FAULT=3 |
| fault_code_o | output | 2 | Sticky fault cause: 0 none, 1 zero period, 2 short period, 3 duty over period |

## Verification
Some properties are checked on every cycle: the output is low in every state other than RUN, FAULT never exits without a clear taken with enable low, CHECK never lasts two cycles, RUN is only held after a cycle with a legal staged pair, the fault code stays fixed while in FAULT, and the count never leaves its range. Other behaviour only shows up in the bench scenarios. These are the exact waveform shapes for several period/duty pairs, including the constant-low and constant-high ends, and the deferred switch to a reloaded pair at the period boundary. The bench also checks the fault-code priority and each way an incomplete recovery handshake is refused.

// File: rtl/pwm_guard_pkg.sv
package pwm_guard_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_RUN   = 2'd2,
    ST_FAULT = 2'd3
  } pg_state_e;

  typedef enum logic [1:0] {
    FC_NONE  = 2'd0,
    FC_ZERO  = 2'd1,
    FC_SHORT = 2'd2,
    FC_OVER  = 2'd3
  } pg_fault_e;

endpackage

// File: rtl/pwm_cfg_guard.sv
module pwm_cfg_guard
  import pwm_guard_pkg::*;
#(
  parameter int W          = 32,
  parameter int MIN_PERIOD = 4
) (
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] duty_i,
  output logic         legal_o,
  output pg_fault_e    code_o
);

  localparam logic [W-1:0] MIN_P = W'(MIN_PERIOD);

  logic is_zero;
  logic is_short;
  logic is_over;

  always_comb begin
    is_zero  = (period_i == '0);
    is_short = (period_i < MIN_P);
    is_over  = (duty_i > period_i);
  end

  // priority: zero period, then short period, then duty overrun
  always_comb begin
    if (is_zero)       code_o = FC_ZERO;
    else if (is_short) code_o = FC_SHORT;
    else if (is_over)  code_o = FC_OVER;
    else               code_o = FC_NONE;
    legal_o = (code_o == FC_NONE);
  end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] duty_i,
  input  logic         legal_i,
  input  logic         start_i,
  input  logic         run_i,
  output logic [W-1:0] stg_period_o,
  output logic [W-1:0] stg_duty_o,
  output logic         pwm_o
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] stg_period_q, stg_duty_q;
  logic [W-1:0] act_period_q, act_duty_q;
  logic [W-1:0] cnt_q, cnt_n;
  logic         pend_q, pend_n;
  logic         wrap;
  logic         act_en;
  logic         cnt_en;
  logic         pend_en;

  always_comb begin
    wrap    = run_i && (cnt_q == act_period_q - ONE);
    act_en  = start_i || (wrap && pend_q && legal_i);
    cnt_n   = (!run_i || wrap) ? '0 : cnt_q + ONE;
    cnt_en  = (cnt_n != cnt_q);
    if (load_i)      pend_n = 1'b1;
    else if (act_en) pend_n = 1'b0;
    else             pend_n = pend_q;
    pend_en = (pend_n != pend_q);
  end

  // staging registers, written by the load strobe in any state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_period_q <= '0;
      stg_duty_q   <= '0;
    end else if (load_i) begin
      stg_period_q <= period_i;
      stg_duty_q   <= duty_i;
    end
  end

  // active registers, updated on run start or at a period boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_period_q <= '0;
      act_duty_q   <= '0;
    end else if (act_en) begin
      act_period_q <= stg_period_q;
      act_duty_q   <= stg_duty_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign stg_period_o = stg_period_q;
  assign stg_duty_o   = stg_duty_q;
  assign pwm_o        = run_i && (cnt_q < act_duty_q);

  // count stays inside the active period while running (R4)
  p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q < act_period_q));

  // active values never change in the middle of a period (R7)
  p_act_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !wrap) |=> $stable(act_period_q) && $stable(act_duty_q));

endmodule

// File: rtl/pwm_supervisor.sv
module pwm_supervisor
  import pwm_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable_req,
  input  logic      clear_i,
  input  logic      legal_i,
  input  pg_fault_e code_i,
  output pg_state_e state_o,
  output pg_fault_e fault_code_o
);

  pg_state_e state_q, state_n;
  pg_fault_e code_q, code_n;
  logic      arm_q, arm_n;
  logic      recover;
  logic      state_en;
  logic      code_en;
  logic      arm_en;

  always_comb begin
    recover = clear_i && arm_q && !enable_req && legal_i;
    state_n = state_q;
    unique case (state_q)
      ST_IDLE:  if (enable_req) state_n = ST_CHECK;
      ST_CHECK: state_n = legal_i ? ST_RUN : ST_FAULT;
      ST_RUN: begin
        if (!legal_i)        state_n = ST_FAULT;
        else if (!enable_req) state_n = ST_IDLE;
      end
      ST_FAULT: if (recover) state_n = ST_IDLE;
      default:  state_n = ST_FAULT;
    endcase
    state_en = (state_n != state_q);
  end

  always_comb begin
    arm_n  = (state_q == ST_FAULT) && !enable_req;
    arm_en = (arm_n != arm_q);
    if (state_q != ST_FAULT && state_n == ST_FAULT) code_n = code_i;
    else if (state_q == ST_FAULT && state_n == ST_IDLE) code_n = FC_NONE;
    else code_n = code_q;
    code_en = (code_n != code_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= ST_IDLE;
    else if (state_en) state_q <= state_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     arm_q <= 1'b0;
    else if (arm_en) arm_q <= arm_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code_q <= FC_NONE;
    else if (code_en) code_q <= code_n;
  end

  assign state_o      = state_q;
  assign fault_code_o = code_q;

  // CHECK never lasts more than one cycle (R2)
  p_check_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK) |=> (state_q != ST_CHECK));

  // RUN is only held after a cycle with a legal staged pair (R3)
  p_run_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> $past(legal_i));

  // FAULT is left only through a clear taken with enable low (R6)
  p_fault_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FAULT && !(clear_i && !enable_req)) |=> (state_q == ST_FAULT));

  // fault code frozen while FAULT persists (R9)
  p_code_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FAULT) |=> (state_q != ST_FAULT || $stable(code_q)));

endmodule

// File: rtl/pwm_guard_top.sv
module pwm_guard_top
  import pwm_guard_pkg::*;
#(
  parameter int W          = 32,
  parameter int MIN_PERIOD = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  cfg_period,
  input  logic [W-1:0]  cfg_duty,
  input  logic          cfg_load,
  input  logic          enable_req,
  input  logic          clear_strobe,
  output logic          pwm_out,
  output logic [1:0]    state_o,
  output logic [1:0]    fault_code_o
);

  logic [1:0]   rst_sync_q;
  logic         rst_i_n;
  logic [W-1:0] stg_period;
  logic [W-1:0] stg_duty;
  logic         legal;
  pg_fault_e    guard_code;
  pg_state_e    state;
  pg_fault_e    fault_code;
  logic         run;
  logic         start;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  pwm_cfg_guard #(.W(W), .MIN_PERIOD(MIN_PERIOD)) guard_i (
    .period_i (stg_period),
    .duty_i   (stg_duty),
    .legal_o  (legal),
    .code_o   (guard_code)
  );

  pwm_supervisor sup_i (
    .clk          (clk),
    .rst_n        (rst_i_n),
    .enable_req   (enable_req),
    .clear_i      (clear_strobe),
    .legal_i      (legal),
    .code_i       (guard_code),
    .state_o      (state),
    .fault_code_o (fault_code)
  );

  assign run   = (state == ST_RUN);
  assign start = (state == ST_CHECK) && legal;

  pwm_timebase #(.W(W)) tb_i (
    .clk          (clk),
    .rst_n        (rst_i_n),
    .load_i       (cfg_load),
    .period_i     (cfg_period),
    .duty_i       (cfg_duty),
    .legal_i      (legal),
    .start_i      (start),
    .run_i        (run),
    .stg_period_o (stg_period),
    .stg_duty_o   (stg_duty),
    .pwm_o        (pwm_out)
  );

  assign state_o      = state;
  assign fault_code_o = fault_code;

  // output low outside RUN, which covers FAULT (R5)
  p_low_off_run_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state != ST_RUN) |-> !pwm_out);

  // a FAULT always carries a non-zero cause (R3)
  p_fault_has_code_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state == ST_FAULT) |-> (fault_code != FC_NONE));

endmodule

// File: tb/pwm_guard_top_tb_top.sv
`timescale 1ns/1ps
module pwm_guard_top_tb_top;

  logic        clk;
  logic        rst_n;
  logic [31:0] cfg_period;
  logic [31:0] cfg_duty;
  logic        cfg_load;
  logic        enable_req;
  logic        clear_strobe;
  logic        pwm_out;
  logic [1:0]  state_o;
  logic [1:0]  fault_code_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  pwm_guard_top dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_period   (cfg_period),
    .cfg_duty     (cfg_duty),
    .cfg_load     (cfg_load),
    .enable_req   (enable_req),
    .clear_strobe (clear_strobe),
    .pwm_out      (pwm_out),
    .state_o      (state_o),
    .fault_code_o (fault_code_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_cfg(input logic [31:0] p, input logic [31:0] d);
    cfg_period = p;
    cfg_duty   = d;
    cfg_load   = 1'b1;
    step();
    cfg_load   = 1'b0;
  endtask

  task automatic recover();
    enable_req   = 1'b0;
    clear_strobe = 1'b0;
    step();
    clear_strobe = 1'b1;
    step();
    clear_strobe = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cfg_period = '0; cfg_duty = '0; cfg_load = 1'b0;
    enable_req = 1'b0; clear_strobe = 1'b0;
    repeat (3) step();
    chk("R1 state in reset", state_o, 0);
    chk("R1 pwm in reset", pwm_out, 0);
    rst_n = 1'b1;
    repeat (3) step();
    chk("R1 state after reset", state_o, 0);
    chk("R1 code after reset", fault_code_o, 0);
    chk("R1 pwm after reset", pwm_out, 0);
  endtask

  task automatic t_run_pattern();
    load_cfg(5, 2);
    enable_req = 1'b1;
    step();
    chk("R2 check state", state_o, 1);
    chk("R2 pwm low in check", pwm_out, 0);
    step();
    chk("R2 run state", state_o, 2);
    for (int k = 0; k < 15; k++) begin
      chk("R4 pattern 5/2", pwm_out, ((k % 5) < 2) ? 1 : 0);
      step();
    end
    enable_req = 1'b0;
    step();
    chk("R10 idle after drop", state_o, 0);
    chk("R10 pwm low", pwm_out, 0);
  endtask

  task automatic t_zero_fault_recover();
    load_cfg(0, 0);
    enable_req = 1'b1;
    step();
    step();
    chk("R3 zero period fault", state_o, 3);
    chk("R3 zero code", fault_code_o, 1);
    chk("R5 pwm low", pwm_out, 0);
    clear_strobe = 1'b1;
    step();
    clear_strobe = 1'b0;
    chk("R6 clear with enable high", state_o, 3);
    enable_req = 1'b0;
    clear_strobe = 1'b1;
    step();
    clear_strobe = 1'b0;
    chk("R6 clear not armed", state_o, 3);
    step();
    clear_strobe = 1'b1;
    step();
    clear_strobe = 1'b0;
    chk("R6 clear illegal cfg", state_o, 3);
    chk("R6 code kept", fault_code_o, 1);
    load_cfg(5, 5);
    clear_strobe = 1'b1;
    step();
    clear_strobe = 1'b0;
    chk("R6 recovered", state_o, 0);
    chk("R6 code cleared", fault_code_o, 0);
    // duty equal to period: constant high
    enable_req = 1'b1;
    step(); step();
    for (int k = 0; k < 10; k++) begin
      chk("R4 duty=period high", pwm_out, 1);
      step();
    end
    enable_req = 1'b0;
    step();
    load_cfg(5, 0);
    enable_req = 1'b1;
    step(); step();
    for (int k = 0; k < 10; k++) begin
      chk("R4 duty 0 low", pwm_out, 0);
      step();
    end
    enable_req = 1'b0;
    step();
  endtask

  task automatic t_short_sticky();
    load_cfg(2, 3);
    enable_req = 1'b1;
    step(); step();
    chk("R3 short before over", fault_code_o, 2);
    chk("R5 in fault", state_o, 3);
    load_cfg(3, 9);
    step();
    chk("R9 code unchanged", fault_code_o, 2);
    chk("R5 still fault", state_o, 3);
    chk("R5 pwm low", pwm_out, 0);
    load_cfg(8, 4);
    recover();
    chk("R6 back to idle", state_o, 0);
  endtask

  task automatic t_over_fault();
    load_cfg(6, 7);
    enable_req = 1'b1;
    step(); step();
    chk("R3 duty over code", fault_code_o, 3);
    load_cfg(6, 2);
    recover();
    chk("R6 idle after over", state_o, 0);
  endtask

  task automatic t_reload();
    load_cfg(4, 1);
    enable_req = 1'b1;
    step(); step();
    chk("R7 k0", pwm_out, 1);
    step();
    chk("R7 k1", pwm_out, 0);
    cfg_period = 6; cfg_duty = 3; cfg_load = 1'b1;
    step();
    cfg_load = 1'b0;
    for (int k = 2; k < 16; k++) begin
      chk("R7 deferred reload", pwm_out, (k < 4) ? 0 : ((((k - 4) % 6) < 3) ? 1 : 0));
      step();
    end
    cfg_period = 6; cfg_duty = 7; cfg_load = 1'b1;
    step();
    cfg_load = 1'b0;
    chk("R8 still run one cycle", state_o, 2);
    step();
    chk("R8 fault after illegal load", state_o, 3);
    chk("R8 code", fault_code_o, 3);
    chk("R8 pwm low", pwm_out, 0);
    load_cfg(6, 3);
    recover();
    chk("R6 idle after reload fault", state_o, 0);
    chk("R6 code cleared", fault_code_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_run_pattern();
    t_zero_fault_recover();
    t_short_sticky();
    t_over_fault();
    t_reload();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule